// File: doc/BRIEF.md
# Multi-Context Transmit Command Scheduler

This block lets several software contexts post transmit work to one shared transmit engine without a software lock. Each context owns a window of the register space. A write to the descriptor slot of a window posts one buffer descriptor. The block records the descriptor against that window, marks the window busy and places its index on an arrival-ordered service list. A single copy engine takes the head of the list, waits until the shared transmit FIFO has room, runs one DMA copy and reports completion in that window's status word.

A packet can be built from several descriptors. When a descriptor carries the continuation flag, the engine copies that piece, keeps the window at the head of the list and goes idle until the same window posts its next piece. Windows queued behind it wait in their arrival order. When the last piece is copied, the engine commits the whole packet length to the FIFO and moves on to the next window on the list.

The descriptor write port, the status read port and the interrupt and commit pulses are plain control pins. The DMA side uses a request/done handshake: the request stays high with a stable address and length until a one-cycle done pulse arrives. The commit pulse needs no back-pressure, because the engine only starts a copy once the FIFO free space covers the whole packet.

Top module: `tx_multi_ctx_sched`

## Requirements
- R1: A write is decoded as window index = wr_addr[8 +: IDX_W] and slot offset = wr_addr[7:0]. Only offset DESC_OFS (default 8'h20) posts a descriptor. A write to any other offset changes no status and starts no DMA.
- R2: The descriptor layout is length in wr_data[63:44], the continuation flag in bit 43 and the DMA address in bits [39:0]. dma_addr and dma_len present these fields for the window being served.
- R3: A descriptor write to a window whose busy bit is set raises wr_err for one cycle, starting the cycle after the write. The stored descriptor is left unchanged and the list does not grow.
- R4: An accepted write sets the window status to busy only: bit 31 = 1, and bits 30 and 19:0 = 0. The window index is appended to the service list unless it is already the head of the list.
- R5: With tx_en high, a pending head descriptor takes the engine from idle to FIFO-wait. With tx_en low, the engine stays idle and dma_req stays low.
- R6: dma_req is raised only when fifo_free is at least the bytes already assembled for the current packet plus the descriptor length. Until then the engine waits.
- R7: One DMA request is outstanding at a time. dma_req, dma_addr and dma_len hold steady until a dma_done pulse.
- R8: The cycle after dma_done, irq_dma pulses for one cycle. The cycle after that, the window status shows bit 30 (complete) with the copied length in bits 19:0, and busy cleared.
- R9: After a piece with the continuation flag, no commit happens and the window stays at the head. Descriptors from other windows are not served until that window's final piece has been copied.
- R10: After a final piece, commit_valid pulses together with irq_dma, with commit_len equal to the sum of the packet's pieces. The list then advances, and later windows are served in arrival order.
- R11: In rd_txdone, bit 29 is set while fifo_free < cfg_max_copy, and bit 28 is set while fifo_used < cfg_watermark.
- R12: irq_full pulses with a commit when fifo_free minus commit_len is below cfg_max_copy.
- R13: After reset, all window status words are zero, the list is empty, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | OFS_W+IDX_W | Window index and slot offset |
| wr_data | input | 64 | Descriptor word |
| wr_err | output | 1 | Write to a busy window was dropped |
| dma_req | output | 1 | DMA copy request, held until done |
| dma_addr | output | 40 | Source address of the copy |
| dma_len | output | 20 | Byte length of the copy |
| dma_done | input | 1 | One-cycle copy completion pulse |
| fifo_free | input | CNT_W | Free bytes in the transmit FIFO |
| fifo_used | input | CNT_W | Occupied bytes in the transmit FIFO |
| cfg_max_copy | input | CNT_W | Largest single copy size |
| cfg_watermark | input | CNT_W | Low-occupancy threshold |
| commit_valid | output | 1 | Packet committed to the FIFO |
| commit_len | output | CNT_W+1 | Total bytes of the committed packet |
| irq_dma | output | 1 | Copy completion interrupt pulse |
| irq_full | output | 1 | FIFO nearly full interrupt pulse |
| rd_idx | input | IDX_W | Window selected for status read |
| rd_txdone | output | 32 | Status word of the selected window |

## Verification
The hardest state to reach is a partly built packet that holds the engine while another window already has a descriptor queued. The stimulus copies a continuation piece from one window so the engine returns to idle with that window still at the head. It then posts a final descriptor from a second window and watches dma_req stay low for several cycles. Only then does the owning window post its last piece. The test expects that piece first, with the summed commit length, and the waiting window after it. The FIFO-space stall is reached the same way: a descriptor is posted while fifo_free is too small, and fifo_free is raised only after several idle cycles.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  localparam int DESC_W   = 64;
  localparam int LEN_W    = 20;
  localparam int LEN_LSB  = 44;
  localparam int MORE_BIT = 43;
  localparam int DADDR_W  = 40;

  localparam int ST_BUSY = 31;
  localparam int ST_DONE = 30;
  localparam int ST_FULL = 29;
  localparam int ST_LOW  = 28;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FWAIT = 2'd1,
    ENG_COPY  = 2'd2,
    ENG_CDONE = 2'd3
  } eng_state_e;
endpackage

// File: rtl/tx_ctx_regs.sv
module tx_ctx_regs
  import tx_sched_pkg::*;
#(
  parameter int NUM_IF = 4,
  parameter int IDX_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_we,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic [LEN_W-1:0]   acc_len,
  input  logic               acc_more,
  input  logic [DADDR_W-1:0] acc_addr,
  input  logic               fin_we,
  input  logic [IDX_W-1:0]   fin_idx,
  input  logic [LEN_W-1:0]   fin_len,
  input  logic [IDX_W-1:0]   head_idx,
  output logic [LEN_W-1:0]   head_len,
  output logic               head_more,
  output logic [DADDR_W-1:0] head_addr,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_busy,
  output logic               rd_done,
  output logic [LEN_W-1:0]   rd_len,
  output logic [NUM_IF-1:0]  busy_vec
);
  logic [NUM_IF-1:0]  busy_q;
  logic [NUM_IF-1:0]  done_q;
  logic [LEN_W-1:0]   cnt_q  [NUM_IF];
  logic [LEN_W-1:0]   dlen_q [NUM_IF];
  logic [NUM_IF-1:0]  dmore_q;
  logic [DADDR_W-1:0] daddr_q [NUM_IF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      done_q  <= '0;
      dmore_q <= '0;
      for (int i = 0; i < NUM_IF; i++) begin
        cnt_q[i]   <= '0;
        dlen_q[i]  <= '0;
        daddr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_IF; i++) begin
        if (acc_we && acc_idx == IDX_W'(i)) begin
          busy_q[i]  <= 1'b1;
          done_q[i]  <= 1'b0;
          cnt_q[i]   <= '0;
          dlen_q[i]  <= acc_len;
          dmore_q[i] <= acc_more;
          daddr_q[i] <= acc_addr;
        end else if (fin_we && fin_idx == IDX_W'(i)) begin
          busy_q[i] <= 1'b0;
          done_q[i] <= 1'b1;
          cnt_q[i]  <= fin_len;
        end
      end
    end
  end

  assign head_len  = dlen_q[head_idx];
  assign head_more = dmore_q[head_idx];
  assign head_addr = daddr_q[head_idx];
  assign rd_busy   = busy_q[rd_idx];
  assign rd_done   = done_q[rd_idx];
  assign rd_len    = cnt_q[rd_idx];
  assign busy_vec  = busy_q;

  AST_FIN_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fin_we |-> busy_q[fin_idx]);  // R8
  AST_ACC_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> !busy_q[acc_idx]);  // R3
endmodule

// File: rtl/tx_svc_list.sv
module tx_svc_list #(
  parameter int NUM_IF = 4,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic             nonempty,
  output logic             multi
);
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] slot_q [NUM_IF];
  logic [IDX_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < NUM_IF; i++) slot_q[i] <= '0;
    end else begin
      if (push) begin
        slot_q[wr_ptr_q] <= push_idx;
        wr_ptr_q         <= wr_ptr_q + 1'b1;
      end
      if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_idx = slot_q[rd_ptr_q];
  assign nonempty = (cnt_q != '0);
  assign multi    = (cnt_q > CNT_W'(1));

  AST_LIST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CNT_W'(NUM_IF)));  // R4
  AST_LIST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));  // R10
endmodule

// File: rtl/tx_copy_fsm.sv
module tx_copy_fsm
  import tx_sched_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               head_valid,
  input  logic               list_multi,
  input  logic [LEN_W-1:0]   head_len,
  input  logic               head_more,
  input  logic [DADDR_W-1:0] head_addr,
  input  logic [CNT_W-1:0]   fifo_free,
  input  logic [CNT_W-1:0]   cfg_max_copy,
  input  logic               dma_done,
  output logic               dma_req,
  output logic [DADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]   dma_len,
  output logic               fin_we,
  output logic               pop,
  output logic               commit_valid,
  output logic [CNT_W:0]     commit_len,
  output logic               irq_dma,
  output logic               irq_full
);
  localparam int SUM_W = CNT_W + 1;

  eng_state_e     st_q, st_d;
  logic [CNT_W-1:0] asm_q;
  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] after_commit;
  logic             space_ok;
  logic             in_cdone;

  assign total        = {1'b0, asm_q} + SUM_W'(head_len);
  assign space_ok     = {1'b0, fifo_free} >= total;
  assign after_commit = {1'b0, fifo_free} - total;
  assign in_cdone     = (st_q == ENG_CDONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ENG_IDLE:  if (tx_en && head_valid) st_d = ENG_FWAIT;
      ENG_FWAIT: if (head_valid && space_ok) st_d = ENG_COPY;
      ENG_COPY:  if (dma_done) st_d = ENG_CDONE;
      ENG_CDONE: begin
        if (head_more)       st_d = ENG_IDLE;
        else if (list_multi) st_d = ENG_FWAIT;
        else                 st_d = ENG_IDLE;
      end
      default:   st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      asm_q <= '0;
    end else begin
      st_q <= st_d;
      if (in_cdone) begin
        if (head_more) asm_q <= total[CNT_W-1:0];
        else           asm_q <= '0;
      end
    end
  end

  assign dma_req      = (st_q == ENG_COPY);
  assign dma_addr     = head_addr;
  assign dma_len      = head_len;
  assign fin_we       = in_cdone;
  assign pop          = in_cdone && !head_more;
  assign commit_valid = pop;
  assign commit_len   = total;
  assign irq_dma      = in_cdone;
  assign irq_full     = pop && (after_commit < {1'b0, cfg_max_copy});

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_done) |=> dma_req);  // R7
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_done) |=> ($stable(dma_addr) && $stable(dma_len)));  // R7
  AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE && !tx_en) |=> !dma_req);  // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dma |=> !irq_dma);  // R8
  AST_COMMIT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> irq_dma);  // R10
  AST_PIECE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cdone && head_more) |-> !commit_valid);  // R9
endmodule

// File: rtl/tx_multi_ctx_sched.sv
module tx_multi_ctx_sched
  import tx_sched_pkg::*;
#(
  parameter int         NUM_IF   = 4,
  parameter int         OFS_W    = 8,
  parameter logic [7:0] DESC_OFS = 8'h20,
  parameter int         CNT_W    = 20,
  localparam int        IDX_W    = $clog2(NUM_IF),
  localparam int        ADDR_W   = OFS_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [63:0]        wr_data,
  output logic               wr_err,
  output logic               dma_req,
  output logic [DADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]   dma_len,
  input  logic               dma_done,
  input  logic [CNT_W-1:0]   fifo_free,
  input  logic [CNT_W-1:0]   fifo_used,
  input  logic [CNT_W-1:0]   cfg_max_copy,
  input  logic [CNT_W-1:0]   cfg_watermark,
  output logic               commit_valid,
  output logic [CNT_W:0]     commit_len,
  output logic               irq_dma,
  output logic               irq_full,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [31:0]        rd_txdone
);
  logic [IDX_W-1:0]  w_idx;
  logic              slot_hit, acc_we, rej_we, push;
  logic              fin_we, pop;
  logic [NUM_IF-1:0] busy_vec;
  logic [IDX_W-1:0]  head_idx;
  logic              nonempty, multi;
  logic [LEN_W-1:0]  head_len;
  logic              head_more;
  logic [DADDR_W-1:0] head_addr;
  logic              rd_busy, rd_done;
  logic [LEN_W-1:0]  rd_len;
  logic              err_q;

  assign w_idx    = wr_addr[ADDR_W-1:OFS_W];
  assign slot_hit = wr_en && (wr_addr[OFS_W-1:0] == DESC_OFS[OFS_W-1:0]);
  assign acc_we   = slot_hit && !busy_vec[w_idx];
  assign rej_we   = slot_hit && busy_vec[w_idx];
  assign push     = acc_we && !(nonempty && head_idx == w_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= rej_we;
  end
  assign wr_err = err_q;

  tx_ctx_regs #(.NUM_IF(NUM_IF), .IDX_W(IDX_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_we    (acc_we),
    .acc_idx   (w_idx),
    .acc_len   (wr_data[LEN_LSB +: LEN_W]),
    .acc_more  (wr_data[MORE_BIT]),
    .acc_addr  (wr_data[DADDR_W-1:0]),
    .fin_we    (fin_we),
    .fin_idx   (head_idx),
    .fin_len   (head_len),
    .head_idx  (head_idx),
    .head_len  (head_len),
    .head_more (head_more),
    .head_addr (head_addr),
    .rd_idx    (rd_idx),
    .rd_busy   (rd_busy),
    .rd_done   (rd_done),
    .rd_len    (rd_len),
    .busy_vec  (busy_vec)
  );

  tx_svc_list #(.NUM_IF(NUM_IF), .IDX_W(IDX_W)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_idx (w_idx),
    .pop      (pop),
    .head_idx (head_idx),
    .nonempty (nonempty),
    .multi    (multi)
  );

  tx_copy_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .head_valid   (nonempty && busy_vec[head_idx]),
    .list_multi   (multi),
    .head_len     (head_len),
    .head_more    (head_more),
    .head_addr    (head_addr),
    .fifo_free    (fifo_free),
    .cfg_max_copy (cfg_max_copy),
    .dma_done     (dma_done),
    .dma_req      (dma_req),
    .dma_addr     (dma_addr),
    .dma_len      (dma_len),
    .fin_we       (fin_we),
    .pop          (pop),
    .commit_valid (commit_valid),
    .commit_len   (commit_len),
    .irq_dma      (irq_dma),
    .irq_full     (irq_full)
  );

  always_comb begin
    rd_txdone          = '0;
    rd_txdone[ST_BUSY] = rd_busy;
    rd_txdone[ST_DONE] = rd_done;
    rd_txdone[ST_FULL] = fifo_free < cfg_max_copy;
    rd_txdone[ST_LOW]  = fifo_used < cfg_watermark;
    rd_txdone[LEN_W-1:0] = rd_len;
  end

  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));  // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> nonempty);  // R10
endmodule

// File: tb/test_tx_multi_ctx_sched.sv
module test_tx_multi_ctx_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en, wr_en, dma_done;
  logic [9:0]  wr_addr;
  logic [63:0] wr_data;
  logic [19:0] fifo_free, fifo_used, cfg_max_copy, cfg_watermark;
  logic [1:0]  rd_idx;
  logic        wr_err, dma_req, commit_valid, irq_dma, irq_full;
  logic [39:0] dma_addr;
  logic [19:0] dma_len;
  logic [20:0] commit_len;
  logic [31:0] rd_txdone;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tx_multi_ctx_sched i_tx_multi_ctx_sched (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_err(wr_err), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_len(dma_len), .dma_done(dma_done), .fifo_free(fifo_free),
    .fifo_used(fifo_used), .cfg_max_copy(cfg_max_copy),
    .cfg_watermark(cfg_watermark), .commit_valid(commit_valid),
    .commit_len(commit_len), .irq_dma(irq_dma), .irq_full(irq_full),
    .rd_idx(rd_idx), .rd_txdone(rd_txdone)
  );

  typedef struct packed {
    logic [1:0]  idx;
    logic [19:0] len;
    logic        more;
    logic [19:0] free;
    logic [20:0] total;
    logic        full;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 20'd100,    1'b0, 20'd1000,   21'd100,    1'b0},
    '{2'd1, 20'd300,    1'b0, 20'd500,    21'd300,    1'b1},
    '{2'd2, 20'd64,     1'b1, 20'd4000,   21'd64,     1'b0},
    '{2'd2, 20'd36,     1'b0, 20'd4000,   21'd100,    1'b0},
    '{2'd3, 20'h01000,  1'b0, 20'h01100,  21'h01000,  1'b0},
    '{2'd1, 20'h00010,  1'b0, 20'h0010F,  21'h00010,  1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic [19:0] len, input logic more,
                                          input logic [39:0] addr);
    return {len, more, 3'b000, addr};
  endfunction

  task automatic post(input logic [1:0] idx, input logic [7:0] ofs, input logic [63:0] d);
    wr_en   = 1'b1;
    wr_addr = {idx, ofs};
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic read_st(input logic [1:0] idx, output logic [31:0] v);
    rd_idx = idx;
    #1;
    v = rd_txdone;
  endtask

  task automatic run_copy(input string tag, input logic [1:0] idx, input logic [39:0] addr,
                          input logic [19:0] len, input logic more,
                          input logic [20:0] total, input logic full);
    logic [31:0] st;
    for (int i = 0; i < 20 && !dma_req; i++) @(negedge clk);
    chk({tag, " R6 request raised"}, dma_req, 1);
    chk({tag, " R2 dma_addr"}, dma_addr, addr);
    chk({tag, " R2 dma_len"}, dma_len, len);
    @(negedge clk);
    chk({tag, " R7 request held"}, dma_req, 1);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    chk({tag, " R8 irq_dma"}, irq_dma, 1);
    chk({tag, " R10 commit_valid"}, commit_valid, !more);
    if (!more) begin
      chk({tag, " R10 commit_len"}, commit_len, total);
      chk({tag, " R12 irq_full"}, irq_full, full);
    end
    @(negedge clk);
    chk({tag, " R8 irq_dma single pulse"}, irq_dma, 0);
    read_st(idx, st);
    chk({tag, " R8 status"}, st & 32'hC00F_FFFF, 32'h4000_0000 | len);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    rst_n = 1'b0; tx_en = 1'b1; wr_en = 1'b0; dma_done = 1'b0;
    wr_addr = '0; wr_data = '0; rd_idx = '0;
    fifo_free = 20'hFFFFF; fifo_used = 20'd100;
    cfg_max_copy = 20'd256; cfg_watermark = 20'd50;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 dma_req", dma_req, 0);
    chk("R13 commit_valid", commit_valid, 0);
    chk("R13 irqs", {irq_dma, irq_full, wr_err}, 0);
    read_st(2'd0, st);
    chk("R13 status zero", st, 0);

    // R1 wrong offset is ignored
    post(2'd1, 8'h28, mk_desc(20'd8, 1'b0, 40'h55));
    repeat (5) @(negedge clk);
    chk("R1 no request", dma_req, 0);
    read_st(2'd1, st);
    chk("R1 status untouched", st, 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [39:0] a;
      a = 40'h1000 * (k + 1) + VEC[k].idx;
      fifo_free = VEC[k].free;
      post(VEC[k].idx, 8'h20, mk_desc(VEC[k].len, VEC[k].more, a));
      chk($sformatf("R3 vec%0d no error", k), wr_err, 0);
      run_copy($sformatf("vec%0d", k), VEC[k].idx, a, VEC[k].len, VEC[k].more,
               VEC[k].total, VEC[k].full);
    end
    fifo_free = 20'hFFFFF;

    // R5 disabled engine, R4 busy status, R3 rejected overwrite
    tx_en = 1'b0;
    post(2'd0, 8'h20, mk_desc(20'd40, 1'b0, 40'hAAA));
    read_st(2'd0, st);
    chk("R4 busy only", st, 32'h8000_0000);
    repeat (6) @(negedge clk);
    chk("R5 no request while disabled", dma_req, 0);
    post(2'd0, 8'h20, mk_desc(20'd77, 1'b0, 40'hBBB));
    chk("R3 wr_err on busy window", wr_err, 1);
    @(negedge clk);
    chk("R3 wr_err one cycle", wr_err, 0);
    tx_en = 1'b1;
    run_copy("R3 first descriptor kept", 2'd0, 40'hAAA, 20'd40, 1'b0, 21'd40, 1'b0);

    // R9 partial owner pins the engine
    post(2'd1, 8'h20, mk_desc(20'd10, 1'b1, 40'h111));
    run_copy("R9 piece", 2'd1, 40'h111, 20'd10, 1'b1, 21'd10, 1'b0);
    post(2'd2, 8'h20, mk_desc(20'd20, 1'b0, 40'h222));
    repeat (8) @(negedge clk);
    chk("R9 other window waits", dma_req, 0);
    post(2'd1, 8'h20, mk_desc(20'd5, 1'b0, 40'h113));
    run_copy("R9 owner final", 2'd1, 40'h113, 20'd5, 1'b0, 21'd15, 1'b0);
    run_copy("R10 next in order", 2'd2, 40'h222, 20'd20, 1'b0, 21'd20, 1'b0);

    // R6 FIFO space wait
    fifo_free = 20'd100;
    post(2'd3, 8'h20, mk_desc(20'd200, 1'b0, 40'h333));
    repeat (8) @(negedge clk);
    chk("R6 stalled on space", dma_req, 0);
    fifo_free = 20'd300;
    run_copy("R6 resumes", 2'd3, 40'h333, 20'd200, 1'b0, 21'd200, 1'b1);
    fifo_free = 20'hFFFFF;

    // R11 status flags
    fifo_free = 20'd10;
    read_st(2'd0, st);
    chk("R11 full flag set", st[29], 1);
    fifo_free = 20'hFFFFF;
    read_st(2'd0, st);
    chk("R11 full flag clear", st[29], 0);
    fifo_used = 20'd10;
    read_st(2'd0, st);
    chk("R11 low flag set", st[28], 1);
    fifo_used = 20'd100;
    read_st(2'd0, st);
    chk("R11 low flag clear", st[28], 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule